// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block forms the second operand of a data-processing instruction. It takes a 32-bit operand, a two-bit shift kind, a shift amount, a flag saying whether that amount came from the instruction word or from a register, and the current carry flag. It returns the shifted operand and the carry that the shift produces. It is purely combinational and has no clock.

An immediate amount is five bits wide. Its value zero does not mean "no shift" for every kind: for right shifts it stands for a shift by the full width, and for rotate it stands for a one-bit rotate through the carry flag. A register amount uses the low eight bits of the source register. Values of the word width or more saturate, each with its own carry rule. For rotate, only the low five bits of a register amount are used.

Top module: `opsh_unit`

## Requirements
- R1: `kind_i` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. When `amt_from_reg_i` is 0 the amount is `amt_i[4:0]`. When it is 1 the amount is all of `amt_i` (0 to 255). With every input at zero the result is zero and the carry is zero.
- R2: Immediate logical left by 0 passes the operand unchanged, and the carry-out equals `carry_i`.
- R3: Immediate logical right by 0 acts as a shift by 32. The result is zero and the carry-out is operand bit 31.
- R4: Immediate rotate right by 0 rotates through carry. The result is {`carry_i`, operand[31:1]} and the carry-out is operand bit 0.
- R5: Immediate arithmetic right by 0 acts as a shift by 32. Every result bit equals operand bit 31, and so does the carry-out.
- R6: For an amount n from 1 to 31, from either source, the result is the ordinary shift or rotate by n. The carry-out is the last bit shifted out: operand bit 32-n for a left shift, and operand bit n-1 for the other kinds.
- R7: A register amount of 0 passes the operand unchanged with carry-out = `carry_i`, for all four kinds.
- R8: A register logical left or logical right by 32 or more gives zero. At exactly 32 the carry-out is bit 0 (left) or bit 31 (right). Above 32 the carry-out is 0.
- R9: A register arithmetic right by 32 or more fills the result with bit 31, and the carry-out is bit 31.
- R10: A register rotate uses only amount bits [4:0]. When those bits are zero but the amount is nonzero, the result is the operand unchanged and the carry-out is bit 31.
- R11: For an immediate amount, `amt_i[7:5]` has no effect on the result or the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to be shifted |
| kind_i | input | 2 | Shift kind (see R1) |
| amt_i | input | 8 | Shift amount |
| amt_from_reg_i | input | 1 | 1: amount from a register, 0: from an immediate |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Two things are decided in the same evaluation: the shifted data and the carry. Each can take a special case on its own while the other stays ordinary. Rotate-through-carry is one example: the carry input enters the result while operand bit 0 leaves as the carry. The exact-32 register shift is another: the data is all zeros while the carry is a live operand bit. The bench drives these pairings directed, and then drives random operands over every kind, both sources and the amounts 0, 1, 31, 32, 33 and 255. For each case a wide-word reference model computes the result and the carry together, and the scoreboard judges both from one sample.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  // How the amount is treated after the special encodings are resolved
  typedef enum logic [2:0] {
    AC_NONE = 3'd0,  // operand passes untouched
    AC_PART = 3'd1,  // ordinary shift by 1..WIDTH-1
    AC_FULL = 3'd2,  // shift by exactly WIDTH
    AC_OVER = 3'd3,  // shift by more than WIDTH
    AC_RRX  = 3'd4,  // one-bit rotate through carry
    AC_WRAP = 3'd5   // register rotate by a nonzero multiple of WIDTH
  } amt_class_e;

endpackage

// File: rtl/opsh_amount_decode.sv
module opsh_amount_decode
  import opsh_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amt,
  input  logic             from_reg,
  input  shift_kind_e      kind,
  output amt_class_e       cls,
  output logic [SH_W-1:0]  cnt
);

  logic [SH_W-1:0] low_bits;
  logic            high_nz;
  logic            eq_width;

  assign low_bits = amt[SH_W-1:0];
  assign high_nz  = |amt[AMT_W-1:SH_W];
  assign eq_width = (amt == AMT_W'(WIDTH));
  assign cnt      = low_bits;

  function automatic amt_class_e imm_class(input shift_kind_e k, input logic [SH_W-1:0] n);
    if (n != '0)       return AC_PART;
    else if (k == SH_LSL) return AC_NONE;
    else if (k == SH_ROR) return AC_RRX;
    else               return AC_FULL;
  endfunction

  function automatic amt_class_e reg_class(input shift_kind_e k, input logic [SH_W-1:0] n,
                                           input logic hi, input logic eq);
    if (n == '0 && !hi)  return AC_NONE;
    else if (k == SH_ROR) return (n == '0) ? AC_WRAP : AC_PART;
    else if (!hi)        return AC_PART;
    else if (eq)         return AC_FULL;
    else                 return AC_OVER;
  endfunction

  always_comb begin
    if (from_reg) cls = reg_class(kind, low_bits, high_nz, eq_width);
    else          cls = imm_class(kind, low_bits);
  end

endmodule

// File: rtl/opsh_rotator.sv
module opsh_rotator #(
  parameter int WIDTH = 32,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SH_W-1:0]  rot,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = rot[s] ? {stage[s][STEP-1:0], stage[s][WIDTH-1:STEP]} : stage[s];
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/opsh_carry_pick.sv
module opsh_carry_pick
  import opsh_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd,
  input  shift_kind_e      kind,
  input  amt_class_e       cls,
  input  logic [SH_W-1:0]  cnt,
  input  logic             cin,
  output logic             cout
);

  // Position of the last bit to leave the word for an ordinary shift
  function automatic logic [SH_W-1:0] last_out(input shift_kind_e k, input logic [SH_W-1:0] n);
    if (k == SH_LSL) return ~n + 1'b1;   // WIDTH - n
    else             return n - 1'b1;
  endfunction

  logic [SH_W-1:0] part_idx;
  assign part_idx = last_out(kind, cnt);

  always_comb begin
    unique case (cls)
      AC_NONE: cout = cin;
      AC_PART: cout = opnd[part_idx];
      AC_FULL: cout = (kind == SH_LSL) ? opnd[0] : opnd[WIDTH-1];
      AC_OVER: cout = (kind == SH_ASR) ? opnd[WIDTH-1] : 1'b0;
      AC_RRX:  cout = opnd[0];
      AC_WRAP: cout = opnd[WIDTH-1];
      default: cout = cin;
    endcase
  end

endmodule

// File: rtl/opsh_unit.sv
module opsh_unit
  import opsh_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [1:0]       kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             amt_from_reg_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);

  localparam int SH_W = $clog2(WIDTH);

  shift_kind_e      kind;
  amt_class_e       amt_cls;
  logic [SH_W-1:0]  cnt;
  logic [SH_W-1:0]  rot_cnt;
  logic [WIDTH-1:0] rotated;
  logic [WIDTH-1:0] mask_r;
  logic [WIDTH-1:0] mask_l;
  logic [WIDTH-1:0] fill;
  logic [WIDTH-1:0] part_res;
  logic [WIDTH-1:0] sat_res;

  assign kind = shift_kind_e'(kind_i);

  opsh_amount_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .amt      (amt_i),
    .from_reg (amt_from_reg_i),
    .kind     (kind),
    .cls      (amt_cls),
    .cnt      (cnt)
  );

  // A left shift is a right rotate by WIDTH - n followed by masking
  assign rot_cnt = (kind == SH_LSL) ? (~cnt + 1'b1) : cnt;

  opsh_rotator #(.WIDTH(WIDTH)) u_rot (
    .din  (opnd_i),
    .rot  (rot_cnt),
    .dout (rotated)
  );

  assign mask_r = {WIDTH{1'b1}} >> cnt;
  assign mask_l = {WIDTH{1'b1}} << cnt;
  assign fill   = {WIDTH{opnd_i[WIDTH-1]}};

  always_comb begin
    unique case (kind)
      SH_LSL: part_res = rotated & mask_l;
      SH_LSR: part_res = rotated & mask_r;
      SH_ASR: part_res = (rotated & mask_r) | (fill & ~mask_r);
      default: part_res = rotated;
    endcase
  end

  assign sat_res = (kind == SH_ASR) ? fill : '0;

  always_comb begin
    unique case (amt_cls)
      AC_PART:         result_o = part_res;
      AC_FULL,
      AC_OVER:         result_o = sat_res;
      AC_RRX:          result_o = {carry_i, opnd_i[WIDTH-1:1]};
      default:         result_o = opnd_i;
    endcase
  end

  opsh_carry_pick #(.WIDTH(WIDTH)) u_carry (
    .opnd (opnd_i),
    .kind (kind),
    .cls  (amt_cls),
    .cnt  (cnt),
    .cin  (carry_i),
    .cout (carry_o)
  );

endmodule

// File: rtl/opsh_unit_chk.sv
module opsh_unit_chk
  import opsh_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic [1:0]       kind_i,
  input logic [AMT_W-1:0] amt_i,
  input logic             amt_from_reg_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input amt_class_e       amt_cls
);

  localparam int SH_W = $clog2(WIDTH);

  logic known;
  logic imm_zero;
  logic reg_wide;

  assign known    = !$isunknown({opnd_i, kind_i, amt_i, amt_from_reg_i, carry_i});
  assign imm_zero = !amt_from_reg_i && (amt_i[SH_W-1:0] == '0);
  assign reg_wide = amt_from_reg_i && (amt_i >= AMT_W'(WIDTH));

  always_comb begin
    if (known) begin
      // register amount zero: untouched operand, carry passes
      p_reg_zero_pass_r7: assert (!(amt_from_reg_i && amt_i == '0) ||
                                  (result_o == opnd_i && carry_o == carry_i));
      // rotate through carry
      p_rrx_r4: assert (!(imm_zero && kind_i == 2'd3) ||
                        (result_o == {carry_i, opnd_i[WIDTH-1:1]} && carry_o == opnd_i[0]));
      // immediate logical right zero means full shift
      p_imm_lsr_full_r3: assert (!(imm_zero && kind_i == 2'd1) ||
                                 (result_o == '0 && carry_o == opnd_i[WIDTH-1]));
      // arithmetic saturation
      p_asr_fill_r9: assert (!(kind_i == 2'd2 && (reg_wide || imm_zero)) ||
                             (result_o == {WIDTH{opnd_i[WIDTH-1]}} && carry_o == opnd_i[WIDTH-1]));
      // wide logical shifts clear the word
      p_wide_logic_zero_r8: assert (!(reg_wide && kind_i[1] == 1'b0) || result_o == '0);
      // any rotate by a nonzero count leaves the carry equal to the new top bit
      p_ror_carry_msb_r6: assert (!(kind_i == 2'd3 && amt_cls == AC_PART) ||
                                  carry_o == result_o[WIDTH-1]);
      // register rotate by a multiple of the width
      p_wrap_keep_r10: assert (amt_cls != AC_WRAP ||
                               (result_o == opnd_i && carry_o == opnd_i[WIDTH-1]));
    end
  end

endmodule

bind opsh_unit opsh_unit_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .opnd_i         (opnd_i),
  .kind_i         (kind_i),
  .amt_i          (amt_i),
  .amt_from_reg_i (amt_from_reg_i),
  .carry_i        (carry_i),
  .result_o       (result_o),
  .carry_o        (carry_o),
  .amt_cls        (amt_cls)
);

// File: tb/tb_opsh_unit.sv
module tb_opsh_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_i = '0;
  logic [1:0]  kind_i = '0;
  logic [7:0]  amt_i = '0;
  logic        amt_from_reg_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] res;
    logic        c;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  opsh_unit dut (
    .opnd_i         (opnd_i),
    .kind_i         (kind_i),
    .amt_i          (amt_i),
    .amt_from_reg_i (amt_from_reg_i),
    .carry_i        (carry_i),
    .result_o       (result_o),
    .carry_o        (carry_o)
  );

  // Reference: shifts carried out in a 64-bit word, carry taken from the
  // bit just beyond the result field.
  function automatic logic [32:0] model(input logic [31:0] op, input logic [1:0] k,
                                        input logic [7:0] a, input logic r, input logic ci);
    logic [63:0] w;
    int n;
    if (!r) begin
      n = int'(a[4:0]);
      if (n == 0) begin
        if (k == 2'd0) return {ci, op};
        if (k == 2'd3) return {op[0], ci, op[31:1]};
        n = 32;
      end
    end else begin
      n = int'(a);
      if (n == 0) return {ci, op};
      if (k == 2'd3) begin
        n = n % 32;
        if (n == 0) return {op[31], op};
      end
    end
    case (k)
      2'd0: begin w = {32'd0, op} << n; return {w[32], w[31:0]}; end
      2'd1: begin w = {op, 32'd0} >> n; return {w[31], w[63:32]}; end
      2'd2: begin w = 64'($signed({op, 32'd0}) >>> n); return {w[31], w[63:32]}; end
      default: begin w = {op, op} >> n; return {w[31], w[31:0]}; end
    endcase
  endfunction

  function automatic string classify(input logic [1:0] k, input logic [7:0] a, input logic r);
    if (!r) begin
      if (a[4:0] != 0) return "R6";
      case (k)
        2'd0: return "R2";
        2'd1: return "R3";
        2'd2: return "R5";
        default: return "R4";
      endcase
    end
    if (a == 0) return "R7";
    if (k == 2'd3) return (a[4:0] == 0) ? "R10" : "R6";
    if (a < 32) return "R6";
    return (k == 2'd2) ? "R9" : "R8";
  endfunction

  task automatic drive(input logic [31:0] op, input logic [1:0] k, input logic [7:0] a,
                       input logic r, input logic ci, input string tag);
    exp_t e;
    logic [32:0] m;
    @(posedge clk);
    #1;
    opnd_i = op; kind_i = k; amt_i = a; amt_from_reg_i = r; carry_i = ci;
    m = model(op, k, a, r, ci);
    e.res = m[31:0];
    e.c   = m[32];
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drive_expect(input logic [31:0] op, input logic [1:0] k, input logic [7:0] a,
                              input logic r, input logic ci, input logic [31:0] xr,
                              input logic xc, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    opnd_i = op; kind_i = k; amt_i = a; amt_from_reg_i = r; carry_i = ci;
    e.res = xr; e.c = xc; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares at the falling edge, half a period after the drive
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (result_o !== e.res || carry_o !== e.c) begin
          failures++;
          $display("FAIL %s op=%h kind=%0d amt=%0d reg=%0d cin=%0d actual res=%h c=%0d expected res=%h c=%0d",
                   e.tag, opnd_i, kind_i, amt_i, amt_from_reg_i, carry_i,
                   result_o, carry_o, e.res, e.c);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [7:0] EDGE_AMTS [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1: all-zero inputs
    drive_expect(32'h0, 2'd0, 8'd0, 1'b0, 1'b0, 32'h0, 1'b0, "R1");
    // R1: kind encoding, each kind by 4 on one operand
    drive_expect(32'h8000_00F1, 2'd0, 8'd4, 1'b0, 1'b0, 32'h0000_0F10, 1'b0, "R1");
    drive_expect(32'h8000_00F1, 2'd1, 8'd4, 1'b0, 1'b0, 32'h0800_000F, 1'b0, "R1");
    drive_expect(32'h8000_00F1, 2'd2, 8'd4, 1'b0, 1'b0, 32'hF800_000F, 1'b0, "R1");
    drive_expect(32'h8000_00F1, 2'd3, 8'd4, 1'b0, 1'b0, 32'h1800_000F, 1'b0, "R1");
    // R2 .. R5 immediate zero encodings
    drive_expect(32'hDEAD_BEEF, 2'd0, 8'd0, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b1, "R2");
    drive_expect(32'h8000_0001, 2'd1, 8'd0, 1'b0, 1'b0, 32'h0, 1'b1, "R3");
    drive_expect(32'h0000_0003, 2'd3, 8'd0, 1'b0, 1'b1, 32'h8000_0001, 1'b1, "R4");
    drive_expect(32'h0000_0002, 2'd3, 8'd0, 1'b0, 1'b0, 32'h0000_0001, 1'b0, "R4");
    drive_expect(32'h9000_0000, 2'd2, 8'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, "R5");
    drive_expect(32'h7000_0000, 2'd2, 8'd0, 1'b0, 1'b1, 32'h0, 1'b0, "R5");
    // R6 ordinary amounts, carry the last bit out
    drive_expect(32'h8000_0000, 2'd0, 8'd1, 1'b0, 1'b0, 32'h0, 1'b1, "R6");
    drive_expect(32'h0000_0001, 2'd1, 8'd1, 1'b1, 1'b0, 32'h0, 1'b1, "R6");
    drive_expect(32'h0000_0001, 2'd3, 8'd31, 1'b1, 1'b0, 32'h0000_0002, 1'b0, "R6");
    // R7 register zero for each kind
    for (int k = 0; k < 4; k++)
      drive_expect(32'hA5A5_0F0F, 2'(k), 8'd0, 1'b1, 1'b1, 32'hA5A5_0F0F, 1'b1, "R7");
    // R8 exact width and beyond
    drive_expect(32'h0000_0001, 2'd0, 8'd32, 1'b1, 1'b0, 32'h0, 1'b1, "R8");
    drive_expect(32'h8000_0000, 2'd1, 8'd32, 1'b1, 1'b0, 32'h0, 1'b1, "R8");
    drive_expect(32'hFFFF_FFFF, 2'd0, 8'd33, 1'b1, 1'b1, 32'h0, 1'b0, "R8");
    drive_expect(32'hFFFF_FFFF, 2'd1, 8'd255, 1'b1, 1'b1, 32'h0, 1'b0, "R8");
    // R9 arithmetic saturation
    drive_expect(32'h8000_0000, 2'd2, 8'd200, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, "R9");
    drive_expect(32'h7FFF_FFFF, 2'd2, 8'd32, 1'b1, 1'b1, 32'h0, 1'b0, "R9");
    // R10 register rotate by multiples of 32 and by 32+4
    drive_expect(32'h8000_1234, 2'd3, 8'd64, 1'b1, 1'b0, 32'h8000_1234, 1'b1, "R10");
    drive_expect(32'h0000_1234, 2'd3, 8'd32, 1'b1, 1'b1, 32'h0000_1234, 1'b0, "R10");
    drive_expect(32'h8000_00F1, 2'd3, 8'd36, 1'b1, 1'b0, 32'h1800_000F, 1'b0, "R10");
    // R11 upper immediate bits ignored: 0xE3 acts as 3, 0xE0 as 0
    drive_expect(32'h0000_00F0, 2'd1, 8'hE3, 1'b0, 1'b0, 32'h0000_001E, 1'b0, "R11");
    drive_expect(32'h1234_5678, 2'd0, 8'hE0, 1'b0, 1'b1, 32'h1234_5678, 1'b1, "R11");

    // Random sweep against the reference model
    for (int i = 0; i < 800; i++) begin
      logic [7:0] a;
      logic [1:0] k;
      logic       r;
      k = 2'($urandom_range(0, 3));
      r = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) != 0) a = EDGE_AMTS[$urandom_range(0, 5)];
      else                           a = 8'($urandom);
      drive($urandom, k, a, r, 1'($urandom_range(0, 1)), classify(k, a, r));
    end

    @(posedge clk);
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule